// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This controller regulates the current in one bridge of a two-phase motor drive. While the bridge is on, the winding current rises until an external sense comparator reports that it is above the reference. The controller then switches the bridge off for a programmed number of clock cycles, after which it switches it back on. The chopping period therefore follows the current rise time rather than a fixed clock. Any gate dead time added downstream extends the real off interval at the bridge, but the controller reports only its own off interval.

Each turn-on starts a blanking window. During that window the comparator is ignored, so that the recovery spike of the freewheeling diodes cannot start a new off interval. A minimum on-time is also enforced. A comparator trip that arrives after blanking but before the minimum on-time has elapsed is remembered and acted on once the minimum is reached. The comparator input is asynchronous and passes through a two-flop synchronizer. The off, blanking and minimum-on lengths are cycle counts. Each count is captured when its interval starts.

With a 16-bit count, every interval can span up to 65535 cycles. A 100 kHz chopping rate therefore fits with wide margin at any practical system clock. A low enable input forces the bridge off and holds all timers in their reset state.

Top module: `coff_chopper`

## Requirements
- R1: While `en_i` is low at a rising edge, after that edge `phase_o` is 2'b00 and `chop_on_o` is 0, whatever the comparator does.
- R2: When `en_i` is sampled high in the disabled phase, the next edge enters the blanked-on phase (2'b01) with `chop_on_o` high.
- R3: The blanked-on phase lasts max(B,1) cycles, where B is `blank_cyc_i`. A comparator high seen by the controller only within that window is discarded and is not remembered.
- R4: A comparator high sampled at edge k, while the phase is on and the minimum on-time is met, puts the phase into off (2'b11) after edge k+2.
- R5: The off phase lasts max(O,1) cycles, where O is `off_cyc_i`. It then returns to the blanked-on phase with `chop_on_o` high.
- R6: Counting blanked-on and on cycles together, the on time lasts at least M cycles, where M is `min_on_i`. A trip seen in the on phase before M is reached is held, and it ends the on time exactly after the M-th on cycle.
- R7: `blank_cyc_i` and `min_on_i` are captured when the blanked-on phase starts, and `off_cyc_i` is captured when the off phase starts. Changes during an interval have no effect on that interval.
- R8: The phase codes are 2'b00 disabled, 2'b01 blanked-on, 2'b10 on and 2'b11 off. `chop_on_o` is high exactly in codes 2'b01 and 2'b10.
- R9: With no comparator trip, the on phase lasts indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable request |
| over_ref_i | input | 1 | Asynchronous sense comparator output, high when current exceeds reference |
| off_cyc_i | input | CNT_W | Off interval length in cycles |
| blank_cyc_i | input | CNT_W | Blanking window length in cycles |
| min_on_i | input | CNT_W | Minimum on time in cycles |
| chop_on_o | output | 1 | Bridge on command to gate logic |
| phase_o | output | 2 | Current phase code |

## Verification
A wrong interval count shows directly on `phase_o`: the off or blanked-on code lasts one cycle too long or too short, and the error is visible on the edge where the phase should have changed. If a trip wrongly survives blanking, the on phase ends early, at the first edge after the minimum is met. If a held trip is lost, the on phase never ends, which stands out because the bench expects an off code at an exact cycle. A synchronizer with the wrong depth moves every trip-driven turn-off by one edge.

// File: rtl/coff_chop_pkg.sv
package coff_chop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_BLANK = 2'b01,
    PH_ON    = 2'b10,
    PH_OFF   = 2'b11
  } phase_e;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= d_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAST-1:0], d_i};
    end
  endgenerate

  assign q_o = sr[LAST];
endmodule

// File: rtl/chop_dncnt.sv
module chop_dncnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;

  // last cycle of an interval when one or zero remains
  assign done_o = (cnt <= CNT_W'(1));

  // R5: an idle counter never wraps
  p_cnt_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load_i) |=> (cnt == '0));
endmodule

// File: rtl/chop_ontime.sv
module chop_ontime #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             met_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] min_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      elapsed <= '0;
      min_q   <= '0;
    end else if (start_i) begin
      elapsed <= '0;
      min_q   <= min_i;
    end else if (run_i && elapsed != SAT) begin
      elapsed <= elapsed + 1'b1;
    end

  // the current cycle is on-cycle number elapsed+1
  assign met_o = ({1'b0, elapsed} + (CNT_W+1)'(1)) >= {1'b0, min_q};
endmodule

// File: rtl/coff_chopper.sv
module coff_chopper
  import coff_chop_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             over_ref_i,
  input  logic [CNT_W-1:0] off_cyc_i,
  input  logic [CNT_W-1:0] blank_cyc_i,
  input  logic [CNT_W-1:0] min_on_i,
  output logic             chop_on_o,
  output logic [1:0]       phase_o
);
  phase_e           state, nxt;
  logic             trip_s, iv_done, min_met, pend;
  logic             iv_load, on_start, go_off, on_run;
  logic [CNT_W-1:0] iv_val;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(over_ref_i), .q_o(trip_s));

  chop_dncnt #(.CNT_W(CNT_W)) u_iv (
    .clk(clk), .rst_n(rst_n), .load_i(iv_load), .val_i(iv_val), .done_o(iv_done));

  assign on_run = (state == PH_BLANK) || (state == PH_ON);

  chop_ontime #(.CNT_W(CNT_W)) u_ont (
    .clk(clk), .rst_n(rst_n), .start_i(on_start), .run_i(on_run),
    .min_i(min_on_i), .met_o(min_met));

  assign go_off = (state == PH_ON) && (trip_s || pend) && min_met;

  always_comb begin
    nxt      = state;
    iv_load  = 1'b0;
    iv_val   = blank_cyc_i;
    on_start = 1'b0;
    unique case (state)
      PH_IDLE: begin
        nxt = PH_BLANK; iv_load = 1'b1; on_start = 1'b1;
      end
      PH_BLANK: if (iv_done) nxt = PH_ON;
      PH_ON: if (go_off) begin
        nxt = PH_OFF; iv_load = 1'b1; iv_val = off_cyc_i;
      end
      PH_OFF: if (iv_done) begin
        nxt = PH_BLANK; iv_load = 1'b1; on_start = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
    if (!en_i) begin
      nxt = PH_IDLE; iv_load = 1'b0; on_start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= PH_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= nxt;
      // trips after blanking but before min on-time are held
      if (nxt != PH_ON)                                    pend <= 1'b0;
      else if (state == PH_ON && trip_s && !min_met)       pend <= 1'b1;
    end

  assign chop_on_o = on_run;
  assign phase_o   = state;

  // R1: disable forces the bridge off at the next edge
  p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (phase_o == 2'b00 && !chop_on_o));
  // R3: blanking cannot end in an off phase
  p_blank_no_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_BLANK) |=> (state != PH_OFF));
  // R4: without a synchronized or held trip the on phase does not end
  p_no_spurious_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ON && !trip_s && !pend) |=> (state != PH_OFF));
  // R5: the off phase exits only into blanking or disable
  p_off_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_OFF) |=> (state == PH_OFF || state == PH_BLANK || state == PH_IDLE));
  // R6: no turn-off before the minimum on-time
  p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ON && !min_met) |=> (state != PH_OFF));
endmodule

// File: tb/coff_chopper_tb_top.sv
module coff_chopper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [1:0] IDL = 2'b00, BLK = 2'b01, ONP = 2'b10, OFP = 2'b11;

  logic clk = 1'b0;
  logic rst_n, en, trip;
  logic [W-1:0] off_c, blank_c, min_c;
  logic chop_on_o;
  logic [1:0] phase_o;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [1:0] ph; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  coff_chopper #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .over_ref_i(trip),
    .off_cyc_i(off_c), .blank_cyc_i(blank_c), .min_on_i(min_c),
    .chop_on_o(chop_on_o), .phase_o(phase_o));

  // monitor: compares each produced cycle with the scoreboard
  always @(negedge clk) begin
    exp_t e;
    logic ech;
    if (q.size() > 0) begin
      e = q.pop_front();
      ech = (e.ph == BLK) || (e.ph == ONP); // R8 chop follows phase code
      checks++;
      if (phase_o !== e.ph || chop_on_o !== ech) begin
        fails++;
        $display("FAIL %s (R8 chop): phase=%b chop=%b expected phase=%b chop=%b",
                 e.tag, phase_o, chop_on_o, e.ph, ech);
      end
    end
  end

  task automatic step(input logic [1:0] ph, input string tag);
    q.push_back('{ph, tag});
    @(negedge clk); #1;
  endtask

  task automatic steps(input int n, input logic [1:0] ph, input string tag);
    for (int i = 0; i < n; i++) step(ph, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; trip = 0;
    off_c = 5; blank_c = 3; min_c = 6;
    repeat (3) @(negedge clk); #1;
    rst_n = 1;
    steps(2, IDL, "R1 reset/disabled");
    en = 1;
    step(BLK, "R2 turn-on");
    steps(2, BLK, "R3 blank length");
    steps(6, ONP, "R9 stays on");
    // trip past min on-time: off after edge k+2
    trip = 1; step(ONP, "R4 sync delay");
    trip = 0; step(ONP, "R4 sync delay");
    step(OFP, "R4 turn-off");
    off_c = 20; // R7 change during off has no effect
    steps(4, OFP, "R5/R7 off length");
    // trip during blanking is discarded
    trip = 1; step(BLK, "R5 back on");
    trip = 0; step(BLK, "R3 blank");
    step(BLK, "R3 blank");
    steps(10, ONP, "R3 discarded trip");
    // early trip held until min on-time
    off_c = 2; min_c = 12;
    trip = 1; step(ONP, "R4");
    trip = 0; step(ONP, "R4");
    steps(2, OFP, "R5 short off");
    steps(3, BLK, "R7 blank sampled");
    trip = 1; step(ONP, "R6 min on");
    trip = 0; steps(8, ONP, "R6 min on hold");
    step(OFP, "R6 held trip");
    step(OFP, "R5");
    // disable
    en = 0; step(IDL, "R1 disable");
    trip = 1; step(IDL, "R1 ignore trip");
    trip = 0; steps(3, IDL, "R1 ignore trip");
    // zero-length intervals
    blank_c = 0; off_c = 0; min_c = 0;
    en = 1; step(BLK, "R2/R3 zero blank");
    steps(2, ONP, "R3 zero blank");
    trip = 1; step(ONP, "R4");
    trip = 0; step(ONP, "R4");
    step(OFP, "R5 zero off");
    step(BLK, "R5 zero off");
    steps(2, ONP, "R9");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule